// File: doc/BRIEF.md
# Per-Connection Event Status Register Bank

This block keeps the event-status state of an instrument's remote-control interface. Each connection (interface instance) owns an 8-bit latched event register and an 8-bit enable mask. Single-cycle event pulses from the rest of the instrument (command error, execution error, verify timeout, query error, operation-complete request) set fixed bits of the connection's event register, and those bits stay set until the host reads the register. Bit 7 is set in every instance when the block leaves power-up reset. Bits 6 and 1 have no source and always read as 0.

Each instance produces a summary bit. It is 1 while any event bit coincides with a set enable bit. The summary bit is brought out per instance and is also returned at bit 5 of a status byte read. The host reaches one instance at a time through an index and four strobes: read-and-clear the events, write the mask, read the mask, and read the status byte. Read data is combinational in the cycle of the strobe, and any register update happens at the following clock edge. Because every connection has its own copy, a clearing read from one client never destroys events that are pending for another.

Top module: `evstat_top`

## Requirements
- R1: After reset every instance holds event value 0x80 (bit 7, power-on, set) and enable mask 0x00, so every summary bit is 0.
- R2: A one-cycle pulse on a connection's command-error, execution-error, verify-timeout, query-error or operation-complete input sets event bit 5, 4, 3, 2 or 0 of that instance, and the bit stays set until a clearing read.
- R3: Event bits 6 and 1 always read as 0 and never contribute to the summary bit.
- R4: An instance's summary bit equals the OR over all bits of (event AND enable). It is driven on summary_o and appears at bit 5 of the status byte read, and all other status byte bits read 0.
- R5: A host event read returns the current event value in that cycle and leaves the register at 0 after the clock edge.
- R6: When an event pulse arrives in the same cycle as a clearing read of that instance, the read returns the old value and the new event bit is set afterwards.
- R7: A mask write stores all 8 data bits in the selected instance. Mask reads return the stored value and do not change it.
- R8: Any host access to one instance leaves the event registers and masks of all other instances unchanged.
- R9: An index of NUM_INST or above selects no instance. Writes and clearing reads are then ignored, and read data is 0x00.
- R10: When several read strobes are high at once, the event read has priority over the mask read, and the mask read has priority over the status read. With no read strobe, read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cmd_err_i | input | NUM_INST | Command-error pulse, one per instance |
| exe_err_i | input | NUM_INST | Execution-error pulse, one per instance |
| vto_err_i | input | NUM_INST | Verify-timeout pulse, one per instance |
| qry_err_i | input | NUM_INST | Query-error pulse, one per instance |
| opc_req_i | input | NUM_INST | Operation-complete request pulse, one per instance |
| host_sel_i | input | IDX_W | Instance index for host accesses |
| host_ev_rd_i | input | 1 | Read and clear event register |
| host_en_wr_i | input | 1 | Write enable mask from host_wdata_i |
| host_en_rd_i | input | 1 | Read enable mask |
| host_stb_rd_i | input | 1 | Read status byte |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, combinational |
| summary_o | output | NUM_INST | Summary bit per instance |

## Verification
On every cycle the assertions check several properties: event bits never drop without a clearing read, every pulse lands in its bit, a read with no coincident pulse empties the register, the mask holds when it is not written, the unused bits stay at 0, and out-of-range or strobe-free accesses return 0. The bench scenarios are needed for the rest. They show the exact bit position of each event source and the values returned by reads. They also cover the old-value-then-keep-new outcome of a colliding read and pulse, the read priority order, and the fact that clearing one connection leaves the other connections' pending events in place.

// File: rtl/evstat_pkg.sv
package evstat_pkg;
  localparam int EV_W       = 8;
  localparam int BIT_PON    = 7;
  localparam int BIT_CMD    = 5;
  localparam int BIT_EXE    = 4;
  localparam int BIT_VTO    = 3;
  localparam int BIT_QRY    = 2;
  localparam int BIT_OPC    = 0;
  localparam int SB_SUMMARY = 5;

  localparam logic [EV_W-1:0] EV_RESET = EV_W'(1) << BIT_PON;
  localparam logic [EV_W-1:0] EV_LIVE  = (EV_W'(1) << BIT_PON) | (EV_W'(1) << BIT_CMD) |
                                         (EV_W'(1) << BIT_EXE) | (EV_W'(1) << BIT_VTO) |
                                         (EV_W'(1) << BIT_QRY) | (EV_W'(1) << BIT_OPC);

  typedef struct packed {
    logic cmd;
    logic exe;
    logic vto;
    logic qry;
    logic opc;
  } ev_pulse_t;

  // Map the per-cycle pulses onto their event bit positions.
  function automatic logic [EV_W-1:0] evs_set_vec(input ev_pulse_t p);
    logic [EV_W-1:0] v;
    v          = '0;
    v[BIT_CMD] = p.cmd;
    v[BIT_EXE] = p.exe;
    v[BIT_VTO] = p.vto;
    v[BIT_QRY] = p.qry;
    v[BIT_OPC] = p.opc;
    return v & EV_LIVE;
  endfunction

  function automatic logic evs_summary(input logic [EV_W-1:0] ev, input logic [EV_W-1:0] en);
    return |(ev & en);
  endfunction

  function automatic logic [EV_W-1:0] evs_status_byte(input logic summary);
    logic [EV_W-1:0] v;
    v             = '0;
    v[SB_SUMMARY] = summary;
    return v;
  endfunction
endpackage

// File: rtl/evstat_slot.sv
module evstat_slot
  import evstat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  ev_pulse_t       pulse_i,
  input  logic            clr_i,
  input  logic            en_wr_i,
  input  logic [EV_W-1:0] wdata_i,
  output logic [EV_W-1:0] ev_q_o,
  output logic [EV_W-1:0] en_q_o,
  output logic            summary_o
);
  logic [EV_W-1:0] ev_q;
  logic [EV_W-1:0] en_q;
  logic [EV_W-1:0] set_vec;
  logic [EV_W-1:0] ev_kept;

  assign set_vec = evs_set_vec(pulse_i);
  assign ev_kept = clr_i ? '0 : ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= EV_RESET;
    end else begin
      ev_q <= (ev_kept | set_vec) & EV_LIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_wr_i) begin
      en_q <= wdata_i;
    end
  end

  assign ev_q_o    = ev_q;
  assign en_q_o    = en_q;
  assign summary_o = evs_summary(ev_q, en_q);

  // Without a clearing read no event bit may drop (also keeps other instances intact).
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  // A pulse always lands, even when it meets a clearing read (R6).
  assert_pulse_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((ev_q & $past(set_vec)) == $past(set_vec)));

  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_vec == '0) |=> (ev_q == '0));

  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[6] == 1'b0) && (ev_q[1] == 1'b0));

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(en_q));
endmodule

// File: rtl/evstat_decode.sv
module evstat_decode #(
  parameter int NUM_INST = 3,
  parameter int IDX_W    = 2
) (
  input  logic [IDX_W-1:0]    sel_i,
  input  logic                ev_rd_i,
  input  logic                en_wr_i,
  output logic [NUM_INST-1:0] clr_vec_o,
  output logic [NUM_INST-1:0] wr_vec_o,
  output logic                sel_ok_o
);
  logic [NUM_INST-1:0] hit;

  for (genvar i = 0; i < NUM_INST; i++) begin : g_hit
    assign hit[i]       = (sel_i == IDX_W'(i));
    assign clr_vec_o[i] = hit[i] & ev_rd_i;
    assign wr_vec_o[i]  = hit[i] & en_wr_i;
  end

  assign sel_ok_o = |hit;

  always_comb begin
    assert_one_target_R8: assert ($onehot0(clr_vec_o) && $onehot0(wr_vec_o));
  end
endmodule

// File: rtl/evstat_rdmux.sv
module evstat_rdmux
  import evstat_pkg::*;
#(
  parameter int NUM_INST = 3,
  parameter int IDX_W    = 2
) (
  input  logic [IDX_W-1:0]               sel_i,
  input  logic                           ev_rd_i,
  input  logic                           en_rd_i,
  input  logic                           stb_rd_i,
  input  logic [NUM_INST-1:0][EV_W-1:0]  ev_arr_i,
  input  logic [NUM_INST-1:0][EV_W-1:0]  en_arr_i,
  input  logic [NUM_INST-1:0]            sum_vec_i,
  output logic [EV_W-1:0]                rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_INST; i++) begin
      if (sel_i == IDX_W'(i)) begin
        if (ev_rd_i) begin
          rdata_o = ev_arr_i[i];
        end else if (en_rd_i) begin
          rdata_o = en_arr_i[i];
        end else if (stb_rd_i) begin
          rdata_o = evs_status_byte(sum_vec_i[i]);
        end
      end
    end
  end
endmodule

// File: rtl/evstat_top.sv
module evstat_top
  import evstat_pkg::*;
#(
  parameter  int NUM_INST = 3,
  localparam int IDX_W    = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INST-1:0] cmd_err_i,
  input  logic [NUM_INST-1:0] exe_err_i,
  input  logic [NUM_INST-1:0] vto_err_i,
  input  logic [NUM_INST-1:0] qry_err_i,
  input  logic [NUM_INST-1:0] opc_req_i,
  input  logic [IDX_W-1:0]    host_sel_i,
  input  logic                host_ev_rd_i,
  input  logic                host_en_wr_i,
  input  logic                host_en_rd_i,
  input  logic                host_stb_rd_i,
  input  logic [7:0]          host_wdata_i,
  output logic [7:0]          host_rdata_o,
  output logic [NUM_INST-1:0] summary_o
);
  logic [NUM_INST-1:0]           clr_vec;
  logic [NUM_INST-1:0]           wr_vec;
  logic                          sel_ok;
  logic [NUM_INST-1:0][EV_W-1:0] ev_arr;
  logic [NUM_INST-1:0][EV_W-1:0] en_arr;
  logic                          any_rd;

  evstat_decode #(.NUM_INST(NUM_INST), .IDX_W(IDX_W)) u_decode (
    .sel_i     (host_sel_i),
    .ev_rd_i   (host_ev_rd_i),
    .en_wr_i   (host_en_wr_i),
    .clr_vec_o (clr_vec),
    .wr_vec_o  (wr_vec),
    .sel_ok_o  (sel_ok)
  );

  for (genvar i = 0; i < NUM_INST; i++) begin : g_slot
    ev_pulse_t pulse;
    assign pulse = '{cmd: cmd_err_i[i], exe: exe_err_i[i], vto: vto_err_i[i],
                     qry: qry_err_i[i], opc: opc_req_i[i]};

    evstat_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .pulse_i   (pulse),
      .clr_i     (clr_vec[i]),
      .en_wr_i   (wr_vec[i]),
      .wdata_i   (host_wdata_i),
      .ev_q_o    (ev_arr[i]),
      .en_q_o    (en_arr[i]),
      .summary_o (summary_o[i])
    );
  end

  evstat_rdmux #(.NUM_INST(NUM_INST), .IDX_W(IDX_W)) u_rdmux (
    .sel_i     (host_sel_i),
    .ev_rd_i   (host_ev_rd_i),
    .en_rd_i   (host_en_rd_i),
    .stb_rd_i  (host_stb_rd_i),
    .ev_arr_i  (ev_arr),
    .en_arr_i  (en_arr),
    .sum_vec_i (summary_o),
    .rdata_o   (host_rdata_o)
  );

  assign any_rd = host_ev_rd_i | host_en_rd_i | host_stb_rd_i;

  assert_oob_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> (host_rdata_o == 8'h00));

  assert_no_strobe_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_rd |-> (host_rdata_o == 8'h00));

  assert_status_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stb_rd_i && !host_ev_rd_i && !host_en_rd_i) |-> ((host_rdata_o & 8'hDF) == 8'h00));
endmodule

// File: tb/evstat_top_test.sv
module evstat_top_test;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] cmd_err = '0, exe_err = '0, vto_err = '0, qry_err = '0, opc_req = '0;
  logic [1:0]   sel = '0;
  logic         ev_rd = 1'b0, en_wr = 1'b0, en_rd = 1'b0, stb_rd = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic [N-1:0] summary;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evstat_top #(.NUM_INST(N)) uut (
    .clk (clk), .rst_n (rst_n),
    .cmd_err_i (cmd_err), .exe_err_i (exe_err), .vto_err_i (vto_err),
    .qry_err_i (qry_err), .opc_req_i (opc_req),
    .host_sel_i (sel), .host_ev_rd_i (ev_rd), .host_en_wr_i (en_wr),
    .host_en_rd_i (en_rd), .host_stb_rd_i (stb_rd), .host_wdata_i (wdata),
    .host_rdata_o (rdata), .summary_o (summary)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One clock cycle: pulses {cmd,exe,vto,qry,opc} on instances in imask,
  // host strobes {ev_rd,en_wr,en_rd,stb_rd}; returns read data sampled mid-cycle.
  task automatic cyc(input logic [4:0] kinds, input logic [N-1:0] imask,
                     input logic [3:0] strb, input logic [1:0] s,
                     input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk);
    cmd_err = kinds[4] ? imask : '0;
    exe_err = kinds[3] ? imask : '0;
    vto_err = kinds[2] ? imask : '0;
    qry_err = kinds[1] ? imask : '0;
    opc_req = kinds[0] ? imask : '0;
    {ev_rd, en_wr, en_rd, stb_rd} = strb;
    sel = s;
    wdata = wd;
    #1 rd = rdata;
    @(posedge clk);
    #1;
    cmd_err = '0; exe_err = '0; vto_err = '0; qry_err = '0; opc_req = '0;
    {ev_rd, en_wr, en_rd, stb_rd} = 4'b0000;
  endtask

  task automatic ev_read(input logic [1:0] s, output logic [7:0] rd);
    cyc(5'b0, '0, 4'b1000, s, 8'h00, rd);
  endtask
  task automatic en_write(input logic [1:0] s, input logic [7:0] wd);
    logic [7:0] d;
    cyc(5'b0, '0, 4'b0100, s, wd, d);
  endtask
  task automatic en_read(input logic [1:0] s, output logic [7:0] rd);
    cyc(5'b0, '0, 4'b0010, s, 8'h00, rd);
  endtask
  task automatic sb_read(input logic [1:0] s, output logic [7:0] rd);
    cyc(5'b0, '0, 4'b0001, s, 8'h00, rd);
  endtask
  task automatic pulse(input logic [4:0] kinds, input logic [N-1:0] imask);
    logic [7:0] d;
    cyc(kinds, imask, 4'b0000, 2'd0, 8'h00, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int i = 0; i < N; i++) begin
      en_read(2'(i), d); check("R1 mask after reset", d, 8'h00);
    end
    sb_read(2'd0, d);    check("R1 status after reset", d, 8'h00);
    check("R1 summary after reset", summary, 0);
    ev_read(2'd0, d);    check("R1/R5 power-on event", d, 8'h80);
    ev_read(2'd0, d);    check("R5 cleared after read", d, 8'h00);
  endtask

  task automatic t_events;
    logic [7:0] d;
    ev_read(2'd1, d);    check("R1 inst1 power-on", d, 8'h80);
    pulse(5'b11111, 3'b010);
    pulse(5'b00000, 3'b010);
    ev_read(2'd1, d);    check("R2/R3 all sources sticky", d, 8'h3D);
    pulse(5'b10000, 3'b010);
    ev_read(2'd1, d);    check("R2 command error bit5", d, 8'h20);
    pulse(5'b00100, 3'b010);
    ev_read(2'd1, d);    check("R2 verify timeout bit3", d, 8'h08);
  endtask

  task automatic t_summary;
    logic [7:0] d;
    en_write(2'd2, 8'h10);
    sb_read(2'd2, d);    check("R4 masked out", d, 8'h00);
    pulse(5'b01000, 3'b100);
    sb_read(2'd2, d);    check("R4 status bit5", d, 8'h20);
    check("R4 summary_o", summary, 3'b100);
    en_write(2'd2, 8'h80);
    sb_read(2'd2, d);    check("R4 power-on enabled", d, 8'h20);
    ev_read(2'd2, d);    check("R2 exe bit4 plus power-on", d, 8'h90);
    sb_read(2'd2, d);    check("R4 status after clear", d, 8'h00);
    en_write(2'd2, 8'h42);
    pulse(5'b11111, 3'b100);
    sb_read(2'd2, d);    check("R3 unused bits never summarise", d, 8'h00);
    check("R3 summary_o", summary, 3'b000);
    ev_read(2'd2, d);    check("R3 unused bits read 0", d, 8'h3D);
  endtask

  task automatic t_enable;
    logic [7:0] d;
    en_write(2'd0, 8'hA5);
    en_read(2'd0, d);    check("R7 mask readback", d, 8'hA5);
    en_read(2'd0, d);    check("R7 mask read not destructive", d, 8'hA5);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    pulse(5'b00010, 3'b001);
    cyc(5'b10000, 3'b001, 4'b1000, 2'd0, 8'h00, d);
    check("R6 read returns old value", d, 8'h04);
    ev_read(2'd0, d);    check("R6 colliding event kept", d, 8'h20);
    ev_read(2'd0, d);    check("R5 empty after read", d, 8'h00);
  endtask

  task automatic t_isolation;
    logic [7:0] d;
    pulse(5'b00001, 3'b111);
    check("R4/R8 inst0 summary via opc", summary[0], 1);
    ev_read(2'd1, d);    check("R2 opc bit0", d, 8'h01);
    ev_read(2'd1, d);    check("R5 inst1 cleared", d, 8'h00);
    ev_read(2'd0, d);    check("R8 inst0 untouched", d, 8'h01);
    ev_read(2'd2, d);    check("R8 inst2 untouched", d, 8'h01);
    en_read(2'd2, d);    check("R8 inst2 mask untouched", d, 8'h42);
  endtask

  task automatic t_oob;
    logic [7:0] d;
    pulse(5'b10000, 3'b010);
    cyc(5'b0, '0, 4'b1100, 2'd3, 8'hFF, d);
    check("R9 out-of-range read data", d, 8'h00);
    en_read(2'd0, d);    check("R9 inst0 mask kept", d, 8'hA5);
    en_read(2'd1, d);    check("R9 inst1 mask kept", d, 8'h00);
    en_read(2'd2, d);    check("R9 inst2 mask kept", d, 8'h42);
    ev_read(2'd1, d);    check("R9 inst1 events kept", d, 8'h20);
  endtask

  task automatic t_priority;
    logic [7:0] d;
    pulse(5'b01000, 3'b001);
    cyc(5'b0, '0, 4'b0011, 2'd0, 8'h00, d);
    check("R10 mask over status", d, 8'hA5);
    cyc(5'b0, '0, 4'b1010, 2'd0, 8'h00, d);
    check("R10 event over mask", d, 8'h10);
    cyc(5'b0, '0, 4'b0000, 2'd0, 8'h00, d);
    check("R10 no strobe gives 0", d, 8'h00);
    ev_read(2'd0, d);    check("R10 prioritised read cleared", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_events();
    t_summary();
    t_enable();
    t_collision();
    t_isolation();
    t_oob();
    t_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule